// File: doc/BRIEF.md
# Top-Anchored Write Protection Guard

This block keeps the protection configuration byte of a small nonvolatile data array and judges every program or erase request against it. The byte comes from a fixed location in the array. Storage of that location lies outside this block, so its value arrives on an input and is captured while reset is held. The byte has four fields. An open bit, when clear, locks the whole array. A range-disable bit, when set, removes the range lock. A 3-bit size field chooses how much of the top of the array is locked. Three user flag bits are not used by the check.

The locked range always ends at the last byte of the array. Its length is `2**UNIT_LOG2 * (size + 1)` bytes, which gives 64 to 512 bytes with the defaults. In normal operation software may only move the open and range-disable bits toward the locked state. It may change the size only while the range-disable bit is still set. The user flags cannot be written at all. In debug mode every bit is writable. Each request carries an operation code and a byte address. The block drives a violation flag to the command sequencer in the same cycle. Whole-array erase and erase verify each have their own rule.

Top module: `topprot_guard`

## Requirements
- R1: While `rst_n` is low the configuration register takes the value of `nv_init`, and `cfg_q` shows it from the release of reset. Bit 7 is the open bit, bits 6:4 are the user flags, bit 3 is the range-disable bit and bits 2:0 are the size field.
- R2: With the open bit at 0, a word program (op 0), sector erase (op 1) or sector modify (op 2) at any address raises `viol`, whatever the range-disable and size bits hold.
- R3: With the open bit at 1 and the range-disable bit at 1, ops 0, 1 and 2 never raise `viol`.
- R4: With the open bit at 1 and the range-disable bit at 0, ops 0, 1 and 2 raise `viol` exactly when the address is at or above `2**ADDR_W - 2**UNIT_LOG2*(size+1)`.
- R5: For sector erase and sector modify, address bits 1:0 are dropped and the check uses the 4-byte sector base.
- R6: Whole-array erase (op 3) raises `viol` unless the open and range-disable bits are both 1.
- R7: Erase verify (op 4) never raises `viol`, at any address and with any configuration.
- R8: In normal mode (`dbg_en` low), a write can only clear the open and range-disable bits. Each new value is the AND of the old bit and the written bit.
- R9: In normal mode the size field takes the written bits 2:0 only if the range-disable bit was 1 before the write. Otherwise it is unchanged.
- R10: In normal mode the user flag bits 6:4 are not changed by a write.
- R11: With `dbg_en` high, a write replaces all eight bits with `cfg_wdata`.
- R12: `viol` is 0 when `req_valid` is low, and it is 0 for the unused op codes 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads `nv_init` |
| nv_init | input | 8 | Stored protection byte from the array |
| dbg_en | input | 1 | Debug mode: all bits writable |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data |
| cfg_q | output | 8 | Current configuration byte |
| req_valid | input | 1 | A request is present |
| req_op | input | 3 | 0 program, 1 sector erase, 2 sector modify, 3 whole erase, 4 erase verify |
| req_addr | input | ADDR_W | Byte address of the request |
| viol | output | 1 | Protection violation for the present request |

## Verification
`viol` is a combinational function of the request and the stored byte. The bench therefore changes the request just after a falling edge and samples `viol` 1 ns later, in the same cycle and without waiting for a clock. A configuration write is raised after one falling edge and dropped at the next. `cfg_q` is compared 1 ns after that second falling edge, which is half a cycle after the rising edge that stores the byte. After each reset the stored byte is read once reset has been released, before any write.

// File: rtl/topprot_guard.sv
module topprot_guard #(
  parameter int ADDR_W    = 12,
  parameter int UNIT_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        nv_init,
  input  logic              dbg_en,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_q,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              viol
);
  localparam logic [2:0] OP_PROG   = 3'd0;
  localparam logic [2:0] OP_SERASE = 3'd1;
  localparam logic [2:0] OP_SMOD   = 3'd2;
  localparam logic [2:0] OP_MASS   = 3'd3;
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(1) << ADDR_W;

  logic [7:0] cfg_r, cfg_nxt;
  logic       open_b, dis_b;
  logic [2:0] size_f;

  assign open_b = cfg_r[7];
  assign dis_b  = cfg_r[3];
  assign size_f = cfg_r[2:0];
  assign cfg_q  = cfg_r;

  always_comb begin
    if (dbg_en)
      cfg_nxt = cfg_wdata;
    else
      cfg_nxt = {open_b & cfg_wdata[7], cfg_r[6:4], dis_b & cfg_wdata[3],
                 dis_b ? cfg_wdata[2:0] : size_f};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_r <= nv_init;
    else if (cfg_we)
      cfg_r <= cfg_nxt;
  end

  logic              sector_op;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W:0]   top_len;
  logic              in_range, hit;
  logic              v;

  assign sector_op = (req_op == OP_SERASE) || (req_op == OP_SMOD);
  assign tgt       = sector_op ? {req_addr[ADDR_W-1:2], 2'b00} : req_addr;
  assign top_len   = ((ADDR_W+1)'(size_f) + (ADDR_W+1)'(1)) << UNIT_LOG2;
  assign in_range  = {1'b0, tgt} >= (SPAN - top_len);
  assign hit       = !open_b || (!dis_b && in_range);

  always_comb begin
    case (req_op)
      OP_PROG, OP_SERASE, OP_SMOD: v = hit;
      OP_MASS:                     v = !(open_b && dis_b);
      default:                     v = 1'b0;
    endcase
  end

  assign viol = req_valid && v;
endmodule

module topprot_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbg_en,
  input logic       cfg_we,
  input logic [7:0] cfg_q,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       viol
);
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !dbg_en) |=> cfg_q[6:4] == $past(cfg_q[6:4]));
  p_open_oneway_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !dbg_en && !cfg_q[7]) |=> !cfg_q[7]);
  p_dis_oneway_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !dbg_en && !cfg_q[3]) |=> !cfg_q[3]);
  p_size_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !dbg_en && !cfg_q[3]) |=> cfg_q[2:0] == $past(cfg_q[2:0]));
  p_verify_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd4) |-> !viol);
  p_mass_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && !(cfg_q[7] && cfg_q[3])) |-> viol);
  p_closed_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op <= 3'd2 && !cfg_q[7]) |-> viol);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !viol);
endmodule

bind topprot_guard topprot_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .cfg_we(cfg_we), .cfg_q(cfg_q),
  .req_valid(req_valid), .req_op(req_op), .viol(viol)
);

// File: tb/topprot_guard_tb_top.sv
`timescale 1ns/1ps
module topprot_guard_tb_top;
  localparam int AW = 12;
  localparam int UL = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    nv_init = 8'h00;
  logic          dbg_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_q;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic          viol;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  topprot_guard #(.ADDR_W(AW), .UNIT_LOG2(UL)) dut_i (
    .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .dbg_en(dbg_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .viol(viol)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] v);
    @(negedge clk);
    nv_init = v;
    #1 rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic do_write(input logic [7:0] d, input logic dbg);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d; dbg_en = dbg;
    @(negedge clk);
    cfg_we = 1'b0; dbg_en = 1'b0;
    #1;
  endtask

  task automatic probe(input logic vld, input logic [2:0] op, input int addr);
    req_valid = vld; req_op = op; req_addr = AW'(addr);
    #1;
  endtask

  function automatic int exp_hit(input logic [7:0] b, input int addr);
    int start;
    start = (1 << AW) - ((int'(b[2:0]) + 1) << UL);
    if (!b[7]) return 1;
    if (b[3]) return 0;
    return (addr >= start) ? 1 : 0;
  endfunction

  function automatic logic [7:0] exp_wr(input logic [7:0] o, input logic [7:0] w);
    return {o[7] & w[7], o[6:4], o[3] & w[3], o[3] ? w[2:0] : o[2:0]};
  endfunction

  initial begin
    do_reset(8'h00);
    chk("R1 reset value", cfg_q, 8'h00);
    probe(1'b0, 3'd0, 0);
    chk("R12 idle no viol", viol, 0);

    // R4 / R5: range boundary sweep over every size and address
    for (int s = 0; s < 8; s++) begin
      logic [7:0] b;
      b = 8'h80 | 8'(s);
      do_reset(b);
      for (int a = 0; a < (1 << AW); a++) begin
        probe(1'b1, 3'd0, a);
        chk("R4 program range", viol, exp_hit(b, a));
        probe(1'b1, 3'd1, a);
        chk("R5 sector erase base", viol, exp_hit(b, a & ~3));
        if ((a & 15) == 3) begin
          probe(1'b1, 3'd2, a);
          chk("R5 sector modify base", viol, exp_hit(b, a & ~3));
        end
      end
    end

    // R1, R2, R3, R6, R7, R12: every stored byte
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = 8'(i);
      do_reset(b);
      chk("R1 load from nv_init", cfg_q, b);
      for (int a = 0; a < (1 << AW); a += 509) begin
        probe(1'b1, 3'd0, a);
        if (!b[7]) chk("R2 closed array", viol, 1);
        else if (b[3]) chk("R3 range disabled", viol, 0);
        else chk("R4 program range", viol, exp_hit(b, a));
        probe(1'b1, 3'd4, a);
        chk("R7 erase verify", viol, 0);
      end
      probe(1'b1, 3'd4, (1 << AW) - 1);
      chk("R7 erase verify top", viol, 0);
      probe(1'b1, 3'd3, 5);
      chk("R6 whole erase", viol, (b[7] && b[3]) ? 0 : 1);
      for (int op = 5; op < 8; op++) begin
        probe(1'b1, 3'(op), (1 << AW) - 1);
        chk("R12 unused op", viol, 0);
      end
      probe(1'b0, 3'd3, (1 << AW) - 1);
      chk("R12 idle no viol", viol, 0);
    end

    // R8, R9, R10: normal-mode write rules
    for (int k = 0; k < 32; k++) begin
      logic [7:0] b;
      b = 8'((k % 16) * 17) ^ ((k >= 16) ? 8'h08 : 8'h00);
      for (int w = 0; w < 256; w++) begin
        logic [7:0] e;
        do_reset(b);
        do_write(8'(w), 1'b0);
        e = exp_wr(b, 8'(w));
        chk("R8 open/disable one-way", int'({cfg_q[7], cfg_q[3]}), int'({e[7], e[3]}));
        chk("R9 size write gate", cfg_q[2:0], e[2:0]);
        chk("R10 flags read-only", cfg_q[6:4], b[6:4]);
      end
    end

    // R11: debug mode full access
    do_reset(8'h00);
    do_write(8'hFF, 1'b1);
    chk("R11 debug write all", cfg_q, 8'hFF);
    do_write(8'h3C, 1'b1);
    chk("R11 debug write all", cfg_q, 8'h3C);
    do_write(8'hFF, 1'b0);
    chk("R8 normal after debug", cfg_q, 8'h3F);
    probe(1'b1, 3'd0, 0);
    chk("R2 closed after debug", viol, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule